// File: doc/BRIEF.md
# Serial Shadow-RAM Command Controller

This block models a small serial memory that holds 64 bits in a volatile working array and keeps a non-volatile shadow copy beside it. A host selects the device with a chip-select line and clocks frames in on a serial clock. Each frame begins with a start bit, carries a word address and then a 3-bit instruction. A write frame then supplies one data word. A read frame returns the addressed word on the serial output.

Two permission flags guard the contents. The write-permit flag must be set before any word write or any store. The recall-seen flag is set once a recall has run, from either an instruction or a hardware pin, and a store also needs it. A store copies the working array into the shadow copy and a recall copies it back. Each takes a fixed number of system clock cycles, during which a busy flag is high and all serial traffic is refused. When a store finishes, write permission drops. The serial output has a separate drive-enable so that it can share one pad with the data input.

Top module: `shadow_ram_ctrl`

## Requirements
- R1: With `cs` high, the first rising `sck` edge that samples `din`=1 is the start bit. Zeros before it are skipped. The next 2 rising edges give the word address, most significant bit first, and the 3 after that give the instruction, most significant bit first. Instruction codes: READ=001, WRITE=010, WREN=011, WRDS=100, STORE=101, RECALL=110. Codes 000 and 111 do nothing.
- R2: After a READ instruction, bit 15 of the addressed 16-bit word is on `dout` from the clock after the instruction's last rising edge. Each later rising `sck` edge moves to the next lower bit, for 16 bits in all.
- R3: `dout_en` is high only while read data is being presented. It is low after the 16th read data edge, and one clock after `cs` falls, and `dout` is 0 whenever `dout_en` is low.
- R4: A WRITE frame takes 16 data bits, most significant first. After the 16th rising edge the word is stored at the frame's address if write permission is set, and it is dropped if permission is clear.
- R5: Write permission is clear after reset. WREN sets it and WRDS clears it.
- R6: A RECALL instruction starts a recall. When the recall finishes, all four shadow words replace the working array and the recall-seen flag is set. Write permission is left as it was.
- R7: A rising edge on `hw_recall` while idle starts the same recall as R6. A STORE launched in the same cycle takes precedence.
- R8: STORE starts only when both write permission and the recall-seen flag are set. Otherwise it does nothing. When the store finishes, the shadow copy equals the working array and write permission is clear.
- R9: `busy` is high for exactly OP_CYCLES clocks for each store or recall. A frame that sees `busy` while `cs` is high is ignored entirely, including any READ output, until `cs` falls.
- R10: Lowering `cs` before a frame completes discards that frame with no effect on either array or either flag.
- R11: After reset, `busy` and `dout_en` are low, both arrays read as zero and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cs | input | 1 | Chip select, high during a frame |
| sck | input | 1 | Serial clock; rising edges shift bits |
| din | input | 1 | Serial data in |
| hw_recall | input | 1 | Hardware recall request, rising-edge triggered |
| dout | output | 1 | Serial read data |
| dout_en | output | 1 | Drive enable for the shared data pad |
| busy | output | 1 | High while a store or recall is running |

## Verification
The bench builds the block with 16-bit words, four words, and OP_CYCLES set to 80 instead of the much longer default. With that window, a complete short frame and the start of a READ frame both fall inside one recall. This shows that traffic seen during a busy window is refused, including a READ frame that runs on after busy ends. It also lets the busy length be counted exactly within a short run.

// File: rtl/shadow_ram_pkg.sv
package shadow_ram_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP_LO = 3'b000,
        OP_READ   = 3'b001,
        OP_WRITE  = 3'b010,
        OP_WREN   = 3'b011,
        OP_WRDS   = 3'b100,
        OP_STORE  = 3'b101,
        OP_RECALL = 3'b110,
        OP_NOP_HI = 3'b111
    } srm_op_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_OPC,
        RX_WDATA,
        RX_RDATA,
        RX_SKIP
    } rx_state_e;

endpackage

// File: rtl/srm_frame_rx.sv
module srm_frame_rx
    import shadow_ram_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sck,
    input  logic              din,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cmd_valid,
    output srm_op_e           cmd_op,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              dout,
    output logic              dout_en
);

    localparam int CNT_W = $clog2(WORD_W) + 1;

    typedef struct packed {
        rx_state_e         state;
        logic              sck_prev;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [OP_W-1:0]   op;
        logic [WORD_W-1:0] shreg;
        logic              cmd_valid;
        logic              wr_valid;
    } rx_t;

    rx_t rx_q, rx_d;
    logic sck_rise;
    logic [OP_W-1:0] op_next;

    always_comb begin
        rx_d           = rx_q;
        rx_d.sck_prev  = sck;
        rx_d.cmd_valid = 1'b0;
        rx_d.wr_valid  = 1'b0;
        sck_rise       = sck & ~rx_q.sck_prev;
        op_next        = {rx_q.op[OP_W-2:0], din};

        if (!cs) begin
            rx_d.state = RX_IDLE;
            rx_d.cnt   = '0;
        end else if (busy) begin
            rx_d.state = RX_SKIP;
        end else if (sck_rise) begin
            case (rx_q.state)
                RX_IDLE: begin
                    if (din) begin
                        rx_d.state = RX_ADDR;
                        rx_d.cnt   = '0;
                    end
                end
                RX_ADDR: begin
                    rx_d.addr = ADDR_W'({rx_q.addr, din});
                    if (rx_q.cnt == CNT_W'(ADDR_W - 1)) begin
                        rx_d.state = RX_OPC;
                        rx_d.cnt   = '0;
                    end else begin
                        rx_d.cnt = rx_q.cnt + CNT_W'(1);
                    end
                end
                RX_OPC: begin
                    rx_d.op = op_next;
                    if (rx_q.cnt == CNT_W'(OP_W - 1)) begin
                        rx_d.cnt = '0;
                        case (srm_op_e'(op_next))
                            OP_READ: begin
                                rx_d.state = RX_RDATA;
                                rx_d.shreg = rd_word;
                            end
                            OP_WRITE: rx_d.state = RX_WDATA;
                            default: begin
                                rx_d.state     = RX_SKIP;
                                rx_d.cmd_valid = 1'b1;
                            end
                        endcase
                    end else begin
                        rx_d.cnt = rx_q.cnt + CNT_W'(1);
                    end
                end
                RX_WDATA: begin
                    rx_d.shreg = {rx_q.shreg[WORD_W-2:0], din};
                    if (rx_q.cnt == CNT_W'(WORD_W - 1)) begin
                        rx_d.state    = RX_SKIP;
                        rx_d.wr_valid = 1'b1;
                    end else begin
                        rx_d.cnt = rx_q.cnt + CNT_W'(1);
                    end
                end
                RX_RDATA: begin
                    rx_d.shreg = {rx_q.shreg[WORD_W-2:0], 1'b0};
                    if (rx_q.cnt == CNT_W'(WORD_W - 1)) begin
                        rx_d.state = RX_SKIP;
                    end else begin
                        rx_d.cnt = rx_q.cnt + CNT_W'(1);
                    end
                end
                default: rx_d.state = RX_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rd_addr   = rx_q.addr;
    assign wr_addr   = rx_q.addr;
    assign wr_data   = rx_q.shreg;
    assign wr_valid  = rx_q.wr_valid;
    assign cmd_valid = rx_q.cmd_valid;
    assign cmd_op    = srm_op_e'(rx_q.op);
    assign dout_en   = (rx_q.state == RX_RDATA);
    assign dout      = dout_en & rx_q.shreg[WORD_W-1];

endmodule

// File: rtl/srm_permit.sv
module srm_permit
    import shadow_ram_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  srm_op_e cmd_op,
    input  logic    store_done,
    input  logic    recall_done,
    output logic    wel,
    output logic    rcl
);

    typedef struct packed {
        logic wel;
        logic rcl;
    } permit_t;

    permit_t pm_q, pm_d;

    always_comb begin
        pm_d = pm_q;
        if (store_done) begin
            pm_d.wel = 1'b0;
        end else if (cmd_valid && cmd_op == OP_WREN) begin
            pm_d.wel = 1'b1;
        end else if (cmd_valid && cmd_op == OP_WRDS) begin
            pm_d.wel = 1'b0;
        end
        if (recall_done) begin
            pm_d.rcl = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q <= '0;
        end else begin
            pm_q <= pm_d;
        end
    end

    assign wel = pm_q.wel;
    assign rcl = pm_q.rcl;

endmodule

// File: rtl/srm_timer.sv
module srm_timer #(
    parameter int OP_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_req,
    input  logic recall_req,
    input  logic hw_recall,
    output logic busy,
    output logic store_done,
    output logic recall_done
);

    localparam int CNT_W = $clog2(OP_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic             is_store;
        logic [CNT_W-1:0] cnt;
        logic             hw_prev;
    } tmr_t;

    tmr_t tm_q, tm_d;
    logic hw_rise;
    logic finish;

    always_comb begin
        tm_d         = tm_q;
        tm_d.hw_prev = hw_recall;
        hw_rise      = hw_recall & ~tm_q.hw_prev;
        finish       = tm_q.busy && (tm_q.cnt == '0);

        if (tm_q.busy) begin
            if (finish) begin
                tm_d.busy = 1'b0;
            end else begin
                tm_d.cnt = tm_q.cnt - CNT_W'(1);
            end
        end else if (store_req) begin
            tm_d.busy     = 1'b1;
            tm_d.is_store = 1'b1;
            tm_d.cnt      = CNT_W'(OP_CYCLES - 1);
        end else if (recall_req || hw_rise) begin
            tm_d.busy     = 1'b1;
            tm_d.is_store = 1'b0;
            tm_d.cnt      = CNT_W'(OP_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign busy        = tm_q.busy;
    assign store_done  = finish & tm_q.is_store;
    assign recall_done = finish & ~tm_q.is_store;

endmodule

// File: rtl/srm_storage.sv
module srm_storage #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 4,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              store_done,
    input  logic              recall_done,
    output logic [WORD_W-1:0] rd_word
);

    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] vol;
        logic [WORDS-1:0][WORD_W-1:0] shadow;
    } store_t;

    store_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vol[wr_addr] = wr_data;
        end
        if (store_done) begin
            st_d.shadow = st_q.vol;
        end
        if (recall_done) begin
            st_d.vol = st_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_word = st_q.vol[rd_addr];

endmodule

// File: rtl/shadow_ram_ctrl.sv
module shadow_ram_ctrl
    import shadow_ram_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int WORDS     = 4,
    parameter int OP_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic din,
    input  logic hw_recall,
    output logic dout,
    output logic dout_en,
    output logic busy
);

    localparam int ADDR_W = $clog2(WORDS);

    logic              cmd_valid;
    srm_op_e           cmd_op;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              wel;
    logic              rcl;
    logic              store_req;
    logic              recall_req;
    logic              store_done;
    logic              recall_done;
    logic              wr_en;

    assign store_req  = cmd_valid && (cmd_op == OP_STORE) && wel && rcl;
    assign recall_req = cmd_valid && (cmd_op == OP_RECALL);
    assign wr_en      = wr_valid && wel;

    srm_frame_rx #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .sck       (sck),
        .din       (din),
        .busy      (busy),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    srm_permit u_permit (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .store_done  (store_done),
        .recall_done (recall_done),
        .wel         (wel),
        .rcl         (rcl)
    );

    srm_timer #(
        .OP_CYCLES (OP_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_req   (store_req),
        .recall_req  (recall_req),
        .hw_recall   (hw_recall),
        .busy        (busy),
        .store_done  (store_done),
        .recall_done (recall_done)
    );

    srm_storage #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS),
        .ADDR_W (ADDR_W)
    ) u_storage (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .store_done  (store_done),
        .recall_done (recall_done),
        .rd_word     (rd_word)
    );

endmodule

// File: rtl/shadow_ram_ctrl_chk.sv
module shadow_ram_ctrl_chk #(
    parameter int OP_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic busy,
    input logic dout_en,
    input logic wel,
    input logic rcl,
    input logic store_done,
    input logic recall_done
);

    localparam int RUN_W = $clog2(OP_CYCLES + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= busy ? run_q + RUN_W'(1) : '0;
        end
    end

    assert_cs_low_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !dout_en);

    assert_busy_blocks_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dout_en);

    assert_busy_window_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_q != '0) |-> (run_q == RUN_W'(OP_CYCLES)));

    assert_busy_not_overlong_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RUN_W'(OP_CYCLES)));

    assert_store_drops_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_done |=> !wel);

    assert_recall_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recall_done |=> rcl);

endmodule

bind shadow_ram_ctrl shadow_ram_ctrl_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs          (cs),
    .busy        (busy),
    .dout_en     (dout_en),
    .wel         (wel),
    .rcl         (rcl),
    .store_done  (store_done),
    .recall_done (recall_done)
);

// File: tb/shadow_ram_ctrl_tb.sv
module shadow_ram_ctrl_tb;

    localparam int OPC  = 80;
    localparam int HALF = 4;
    localparam logic [2:0] C_READ = 3'b001, C_WRITE = 3'b010, C_WREN = 3'b011,
                           C_WRDS = 3'b100, C_STORE = 3'b101, C_RECALL = 3'b110;

    logic clk = 1'b0;
    logic rst_n, cs, sck, din, hw_recall;
    logic dout, dout_en, busy;

    always #2 clk = ~clk;

    shadow_ram_ctrl #(.WORD_W(16), .WORDS(4), .OP_CYCLES(OPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .din(din),
        .hw_recall(hw_recall), .dout(dout), .dout_en(dout_en), .busy(busy));

    int checks = 0, fails = 0;
    int mon_cmp = 0, mon_bad = 0;
    int busy_cyc = 0;
    int en_rises = 0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    always @(negedge clk) if (busy) busy_cyc <= busy_cyc + 1;

    // Monitor: collects read bits at each rising sck while output is enabled
    logic [15:0] cap = '0;
    int nb = 0;
    always @(posedge sck) begin
        if (dout_en) begin
            en_rises = en_rises + 1;
            cap = {cap[14:0], dout};
            nb = nb + 1;
            if (nb == 16) begin
                nb = 0;
                mon_cmp = mon_cmp + 1;
                if (exp_q.size() == 0) begin
                    mon_bad = mon_bad + 1;
                    $display("FAIL R2 unexpected read: got %h expected none", cap);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (cap !== e) begin
                        mon_bad = mon_bad + 1;
                        $display("FAIL %s: got %h expected %h", t, cap, e);
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        din = b;
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic fbegin();
        @(negedge clk);
        cs = 1'b1;
        sck = 1'b0;
    endtask

    task automatic fend();
        @(negedge clk);
        cs = 1'b0;
        sck = 1'b0;
        din = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic header(input logic [1:0] a, input logic [2:0] op);
        sbit(1'b1);
        for (int i = 1; i >= 0; i--) sbit(a[i]);
        for (int i = 2; i >= 0; i--) sbit(op[i]);
    endtask

    task automatic cmd(input logic [2:0] op);
        fbegin();
        header(2'd0, op);
        fend();
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        fbegin();
        header(a, C_WRITE);
        for (int i = 15; i >= 0; i--) sbit(d[i]);
        fend();
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        fbegin();
        header(a, C_READ);
        for (int i = 0; i < 16; i++) sbit(1'b0);
        chk({tag, " R3 enable off after data"}, {31'd0, dout_en}, 32'd0);
        fend();
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_all();
        int b0;
        int e0;
        rst_n = 1'b0; cs = 1'b0; sck = 1'b0; din = 1'b0; hw_recall = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 busy after reset", {31'd0, busy}, 32'd0);
        chk("R11 dout_en after reset", {31'd0, dout_en}, 32'd0);
        chk("R3 dout low when idle", {31'd0, dout}, 32'd0);
        for (int a = 0; a < 4; a++) rd(2'(a), 16'h0000, "R11 array cleared");

        // R5/R4: permission clear after reset, write dropped
        wr(2'd1, 16'hA5C3);
        rd(2'd1, 16'h0000, "R4 write without permission");

        cmd(C_WREN);
        wr(2'd1, 16'hA5C3);
        wr(2'd2, 16'h0F0F);
        rd(2'd1, 16'hA5C3, "R4 write word 1");
        rd(2'd2, 16'h0F0F, "R2 read word 2");

        // R1: leading zeros before start bit are skipped
        fbegin();
        sbit(1'b0); sbit(1'b0);
        header(2'd3, C_WRITE);
        for (int i = 15; i >= 0; i--) sbit(((16'h8421 >> i) & 16'h1) != 0);
        fend();
        rd(2'd3, 16'h8421, "R1 leading zeros");

        // R5: WRDS clears permission
        cmd(C_WRDS);
        wr(2'd1, 16'h1111);
        rd(2'd1, 16'hA5C3, "R5 WRDS blocks write");

        // R1: code 000 and 111 do not grant permission
        cmd(3'b000);
        cmd(3'b111);
        wr(2'd2, 16'h2222);
        rd(2'd2, 16'h0F0F, "R1 no-op codes");

        // R8: store refused without a prior recall; permission kept
        cmd(C_WREN);
        b0 = busy_cyc;
        cmd(C_STORE);
        repeat (10) @(negedge clk);
        chk("R8 store refused, no busy", busy_cyc - b0, 0);
        wr(2'd0, 16'h1234);
        rd(2'd0, 16'h1234, "R8 permission kept after refused store");

        // R10: aborted write and aborted WRDS have no effect
        fbegin();
        header(2'd0, C_WRITE);
        for (int i = 0; i < 8; i++) sbit(1'b1);
        fend();
        rd(2'd0, 16'h1234, "R10 partial write dropped");
        fbegin();
        sbit(1'b1); sbit(1'b0); sbit(1'b0); sbit(1'b1); sbit(1'b0);
        fend();
        wr(2'd2, 16'h2222);
        rd(2'd2, 16'h2222, "R10 partial WRDS dropped");

        // R6/R9: software recall, traffic during busy ignored
        b0 = busy_cyc;
        cmd(C_RECALL);
        chk("R9 busy during recall", {31'd0, busy}, 32'd1);
        cmd(C_WRDS);
        e0 = en_rises;
        fbegin();
        header(2'd2, C_READ);
        for (int i = 0; i < 16; i++) sbit(1'b0);
        fend();
        chk("R9 read frame during busy silent", en_rises - e0, 0);
        wait_idle();
        chk("R9 recall busy length", busy_cyc - b0, OPC);
        for (int a = 0; a < 4; a++) rd(2'(a), 16'h0000, "R6 recall restores shadow");
        wr(2'd0, 16'h7777);
        rd(2'd0, 16'h7777, "R6 recall keeps permission, R9 WRDS ignored");

        // R8: store with both flags
        wr(2'd1, 16'hBEEF);
        wr(2'd2, 16'hC0DE);
        wr(2'd3, 16'h0001);
        b0 = busy_cyc;
        cmd(C_STORE);
        wait_idle();
        chk("R9 store busy length", busy_cyc - b0, OPC);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, 16'h7777, "R8 store clears permission");

        // R7: hardware recall brings shadow copy back
        cmd(C_WREN);
        for (int a = 0; a < 4; a++) wr(2'(a), 16'h0000);
        rd(2'd1, 16'h0000, "R4 overwrite before hw recall");
        b0 = busy_cyc;
        @(negedge clk);
        hw_recall = 1'b1;
        repeat (5) @(negedge clk);
        hw_recall = 1'b0;
        wait_idle();
        chk("R7 hw recall busy length", busy_cyc - b0, OPC);
        rd(2'd0, 16'h7777, "R7 hw recall word 0");
        rd(2'd1, 16'hBEEF, "R7 hw recall word 1");
        rd(2'd2, 16'hC0DE, "R7 hw recall word 2");
        rd(2'd3, 16'h0001, "R7 hw recall word 3");
        repeat (4) @(negedge clk);
        chk("R2 all expected reads seen", exp_q.size(), 0);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 checks + mon_cmp, fails + mon_bad);
        $finish;
    end

endmodule